// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by software into asynchronous serial frames on a single output line. A pending-byte register sits in front of a private frame shifter, so software can queue the next byte while the current frame is still going out. Back-to-back frames then leave with no idle time between them.

Timing comes from an external enable pulse, `tick_i`, that runs at OVS times the bit rate. Each bit occupies OVS of these pulses. Two status outputs tell software when to act:
- `buf_empty_o` says when the pending register may be refilled.
- `busy_o` says when the line has gone quiet with nothing left to send.

The pending register can be read back. The shifter cannot.

Top module: `uart_tx_dbuf`

## Requirements
- R1: Out of reset `txd_o` is high, `buf_empty_o` is high and `busy_o` is low.
- R2: A frame is one low start bit, then DATA_W data bits with bit 0 first, then one high stop bit. Between frames the line stays high.
- R3: Every bit of a frame lasts exactly OVS `tick_i` pulses. `txd_o` changes only in the clock that follows a cycle with `tick_i` high.
- R4: When the shifter is idle, a written byte moves out of the pending register on the second clock after the write. `buf_empty_o` returns high on that clock, and the start bit waits for the next `tick_i`.
- R5: Any write drives `buf_empty_o` low on the clock after the write strobe.
- R6: A byte written while a frame is shifting stays pending, with `buf_empty_o` low, until the stop bit of that frame ends. It then moves into the shifter and `buf_empty_o` goes high. Its start bit follows the stop bit with no idle gap, so consecutive start edges are exactly (DATA_W+2)·OVS ticks apart.
- R7: `busy_o` is high from the clock after a write until the stop bit of the last frame has ended with no byte pending. It is low on the following clock.
- R8: `buf_rd_o` returns the most recently written byte. It keeps that value after the byte has moved into the shifter.
- R9: A write while a byte is pending replaces that byte. The frame already shifting is sent unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Enable pulse at OVS times the bit rate |
| wr_en_i | input | 1 | Write strobe for the pending register |
| wr_data_i | input | DATA_W | Byte to write |
| buf_rd_o | output | DATA_W | Readback of the pending register |
| buf_empty_o | output | 1 | High when the pending register may be written |
| busy_o | output | 1 | High while a frame is shifting or a byte is pending |
| txd_o | output | 1 | Serial output line, high when idle |

## Verification
The bench builds the block with DATA_W = 8 and OVS = 4, and pulses `tick_i` every third clock. A bit is therefore 12 clocks long. The small oversampling factor keeps each frame short, so several queued, back-to-back and overwritten frames fit in one run. The slower tick still shows that the line moves only on tick cycles. Because the bench drives the tick itself, it can also pause it to hold a loaded frame at its start, and it can compare the spacing of consecutive start edges against an exact clock count.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;
    // Shifter sequencing: idle, loaded but waiting for a tick, shifting a frame
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_ARMED = 2'd1,
        SH_SHIFT = 2'd2
    } sh_state_e;
endpackage

// File: rtl/utx_holdreg.sv
`timescale 1ns/1ps
module utx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              full
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              full;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.full = 1'b0;
        end
        // a write in the same cycle as a hand-off wins: the new byte stays pending
        if (wr_en) begin
            hold_d.data = wr_data;
            hold_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign hold_data = hold_q.data;
    assign full      = hold_q.full;
endmodule

// File: rtl/utx_bitclk.sv
`timescale 1ns/1ps
module utx_bitclk #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic bit_end
);
    localparam int SUB_W = (OVS > 2) ? $clog2(OVS) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

    typedef struct packed {
        logic [SUB_W-1:0] sub;
    } bclk_t;

    bclk_t bclk_d, bclk_q;

    assign bit_end = run && tick && (bclk_q.sub == SUB_LAST);

    always_comb begin
        bclk_d = bclk_q;
        if (!run) begin
            bclk_d.sub = '0;
        end else if (tick) begin
            bclk_d.sub = (bclk_q.sub == SUB_LAST) ? '0 : bclk_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= '0;
        end else begin
            bclk_q <= bclk_d;
        end
    end
endmodule

// File: rtl/utx_shifter.sv
`timescale 1ns/1ps
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bit_end,
    input  logic              buf_full,
    input  logic [DATA_W-1:0] buf_data,
    output logic              take,
    output logic              running,
    output logic              idle,
    output logic              line
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        sh_state_e          st;
        logic [FRAME_W-1:0] frm;
        logic [CNT_W-1:0]   bitn;
        logic               line;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        take  = 1'b0;
        case (shf_q.st)
            SH_IDLE: begin
                if (buf_full) begin
                    take       = 1'b1;
                    shf_d.st   = SH_ARMED;
                    shf_d.frm  = {1'b1, buf_data, 1'b0};
                    shf_d.bitn = '0;
                end
            end
            SH_ARMED: begin
                if (tick) begin
                    shf_d.st = SH_SHIFT;
                end
            end
            SH_SHIFT: begin
                if (bit_end) begin
                    if (shf_q.bitn == LAST_BIT) begin
                        if (buf_full) begin
                            // stop bit done, next byte goes straight into its start bit
                            take       = 1'b1;
                            shf_d.frm  = {1'b1, buf_data, 1'b0};
                            shf_d.bitn = '0;
                        end else begin
                            shf_d.st  = SH_IDLE;
                            shf_d.frm = '1;
                        end
                    end else begin
                        shf_d.frm  = {1'b1, shf_q.frm[FRAME_W-1:1]};
                        shf_d.bitn = shf_q.bitn + 1'b1;
                    end
                end
            end
            default: begin
                shf_d.st  = SH_IDLE;
                shf_d.frm = '1;
            end
        endcase
        shf_d.line = (shf_d.st == SH_SHIFT) ? shf_d.frm[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shf_q <= '{st: SH_IDLE, frm: '1, bitn: '0, line: 1'b1};
        end else begin
            shf_q <= shf_d;
        end
    end

    assign running = (shf_q.st == SH_SHIFT);
    assign idle    = (shf_q.st == SH_IDLE);
    assign line    = shf_q.line;
endmodule

// File: rtl/uart_tx_dbuf.sv
`timescale 1ns/1ps
module uart_tx_dbuf #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] buf_rd_o,
    output logic              buf_empty_o,
    output logic              busy_o,
    output logic              txd_o
);
    logic              take_w;
    logic              full_w;
    logic [DATA_W-1:0] hold_w;
    logic              run_w;
    logic              idle_w;
    logic              bit_end_w;
    logic              line_w;

    utx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en_i),
        .wr_data   (wr_data_i),
        .take      (take_w),
        .hold_data (hold_w),
        .full      (full_w)
    );

    utx_bitclk #(.OVS(OVS)) u_bclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .run     (run_w),
        .bit_end (bit_end_w)
    );

    utx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_i),
        .bit_end  (bit_end_w),
        .buf_full (full_w),
        .buf_data (hold_w),
        .take     (take_w),
        .running  (run_w),
        .idle     (idle_w),
        .line     (line_w)
    );

    assign buf_rd_o    = hold_w;
    assign buf_empty_o = ~full_w;
    assign busy_o      = ~idle_w | full_w;
    assign txd_o       = line_w;
endmodule

// File: rtl/utx_dbuf_chk.sv
`timescale 1ns/1ps
module utx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic wr_en,
    input logic take,
    input logic txd,
    input logic buf_empty,
    input logic busy
);
    // R1 / R2: with nothing in flight the line rests high
    assert_idle_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    // R3: the line only moves in the clock after a tick
    assert_move_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    // R5: a write always leaves a byte pending in the next clock
    assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !buf_empty);

    // R4 / R6: the buffer only empties through a hand-off to the shifter
    assert_empty_by_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $past(take));

    // R7: a pending byte keeps the block busy
    assert_pending_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_empty |-> busy);

    // R2: a start edge only happens while busy
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> busy);
endmodule

bind uart_tx_dbuf utx_dbuf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_i),
    .wr_en     (wr_en_i),
    .take      (take_w),
    .txd       (txd_o),
    .buf_empty (buf_empty_o),
    .busy      (busy_o)
);

// File: tb/sim_uart_tx_dbuf.sv
`timescale 1ns/1ps
module sim_uart_tx_dbuf;
    localparam int DATA_W = 8;
    localparam int OVS    = 4;
    localparam int TDIV   = 3;
    localparam int BITCLK = OVS * TDIV;
    localparam int FRAMECLK = (DATA_W + 2) * BITCLK;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] buf_rd;
    logic              buf_empty;
    logic              busy;
    logic              txd;

    int  n_cmp = 0;
    int  n_err = 0;
    bit  tick_on = 1'b1;
    longint cyc = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_tx_dbuf #(.DATA_W(DATA_W), .OVS(OVS)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .buf_rd_o    (buf_rd),
        .buf_empty_o (buf_empty),
        .busy_o      (busy),
        .txd_o       (txd)
    );

    // tick generator, driven on the falling edge
    initial begin
        int tcnt;
        tcnt = 0;
        forever begin
            @(negedge clk);
            if (tick_on) begin
                tcnt = (tcnt + 1) % TDIV;
                tick = (tcnt == 0);
            end else begin
                tick = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [DATA_W-1:0] b);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 4 * FRAMECLK && !buf_empty; i++) @(negedge clk);
    endtask

    task automatic wait_quiet();
        for (int i = 0; i < 4 * FRAMECLK && busy; i++) @(negedge clk);
    endtask

    // capture one frame: returns data, start/stop levels and the start-edge cycle
    task automatic rx_frame(output logic [DATA_W-1:0] b, output logic st,
                            output logic sp, output longint t0);
        b = '0;
        for (int i = 0; i < 4 * FRAMECLK && txd; i++) @(negedge clk);
        t0 = cyc;
        repeat (BITCLK / 2) @(negedge clk);
        st = txd;
        for (int k = 0; k < DATA_W; k++) begin
            repeat (BITCLK) @(negedge clk);
            b[k] = txd;
        end
        repeat (BITCLK) @(negedge clk);
        sp = txd;
    endtask

    task automatic t_reset();
        chk("R1 txd", txd, 1);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 busy", busy, 0);
    endtask

    task automatic t_single(input logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] got;
        logic st, sp;
        longint t0;
        do_write(b);
        chk("R5 empty low after write", buf_empty, 0);
        chk("R7 busy after write", busy, 1);
        @(negedge clk);
        chk("R4 empty back high on idle hand-off", buf_empty, 1);
        rx_frame(got, st, sp, t0);
        chk("R2 start bit", st, 0);
        chk("R2 data lsb first", got, b);
        chk("R2 stop bit", sp, 1);
        chk("R7 busy in stop bit", busy, 1);
        chk("R8 readback after hand-off", buf_rd, b);
        repeat (BITCLK) @(negedge clk);
        chk("R7 busy low after stop", busy, 0);
        chk("R2 idle line high", txd, 1);
    endtask

    task automatic t_back2back();
        logic [DATA_W-1:0] g1, g2;
        logic s1, p1, s2, p2;
        longint ta, tb;
        do_write(8'h3C);
        wait_empty();
        do_write(8'hC3);
        chk("R6 second byte pending", buf_empty, 0);
        rx_frame(g1, s1, p1, ta);
        chk("R6 still pending in stop bit", buf_empty, 0);
        chk("R2 first frame data", g1, 8'h3C);
        rx_frame(g2, s2, p2, tb);
        chk("R6 no idle gap between frames", tb - ta, FRAMECLK);
        chk("R3 bit length via frame spacing", (tb - ta) % BITCLK, 0);
        chk("R2 second frame data", g2, 8'hC3);
        chk("R6 empty after reload", buf_empty, 1);
        chk("R7 busy through second frame", busy, 1);
        wait_quiet();
        chk("R7 quiet after last frame", busy, 0);
    endtask

    task automatic t_overwrite();
        logic [DATA_W-1:0] g1, g2;
        logic s, p;
        longint ta, tb;
        do_write(8'h11);
        wait_empty();
        do_write(8'h22);
        do_write(8'h33);
        chk("R8 readback latest", buf_rd, 8'h33);
        rx_frame(g1, s, p, ta);
        chk("R9 shifting frame unaffected", g1, 8'h11);
        rx_frame(g2, s, p, tb);
        chk("R9 pending byte replaced", g2, 8'h33);
        wait_quiet();
    endtask

    task automatic t_tick_hold();
        logic [DATA_W-1:0] g;
        logic s, p;
        longint ta;
        tick_on = 1'b0;
        do_write(8'h5A);
        repeat (30) @(negedge clk);
        chk("R4 start waits for tick", txd, 1);
        chk("R4 byte already taken", buf_empty, 1);
        chk("R7 busy while armed", busy, 1);
        tick_on = 1'b1;
        rx_frame(g, s, p, ta);
        chk("R3 frame after tick resumes", g, 8'h5A);
        wait_quiet();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single(8'hA5);
        t_single(8'h01);
        t_single(8'h80);
        t_back2back();
        t_overwrite();
        t_tick_hold();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule